// File: doc/BRIEF.md
# Counter-Based Phase and Frequency Detector

This block compares two square waves that have already been digitised: a reference input and a local oscillator. It keeps a phase count in whole cycles. Each rising edge on the reference adds one, and each rising edge on the oscillator takes one away. The count is presented as a parallel code for an external DAC. The code is captured only on the falling edge of the oscillator. When the two inputs are locked, that capture falls halfway between counter updates, so the transfer curve is a staircase with one step per full cycle of phase difference.

Around zero error the block raises a match flag. That flag hands control to an external analog mixer, which gives fine phase detection inside the dead zone. Outside the dead zone, this block alone drives the loop back toward lock. Two saturation flags mark when the count has reached a user-set upper or lower limit. While a flag is set, the input that would push the count past its limit is ignored, so the count never wraps.

Both inputs are sampled by a fast system clock. Each input passes through a synchroniser and an edge detector. The output code is a held level, not a stream: it has no handshake and accepts no back-pressure. The DAC reads it at any time.

Top module: `pfd_cycle_detector`

## Requirements
- R1: While `rst` is high on a rising `clk` edge, the design returns to its reset state. In that state `code_o` is the zero-phase code Z = 1 followed by W-2 zeros followed by 1 (129 for W=8), `lock_o` is 1, and `sat_hi_o` and `sat_lo_o` are 0.
- R2: Each accepted rising edge of `rf_i` raises the phase count by one, and each accepted rising edge of `lo_i` lowers it by one. When latched, the code equals Z plus the number of accepted reference edges minus the number of accepted oscillator edges, modulo 2^W.
- R3: `code_o` changes only in the clock cycle after a falling edge of `lo_i` is detected. At all other times it holds its value.
- R4: An input level takes SYNC_STAGES clock edges to reach the edge detector. A rising edge updates the phase count on the next `clk` edge. A falling oscillator edge updates `code_o` on the next `clk` edge. The flags follow `code_o` one clock later.
- R5: `sat_hi_o` is the registered result of `code_o` >= TU. While it is 1, reference edges are ignored and the count cannot rise.
- R6: `sat_lo_o` is the registered result of `code_o` <= TL. While it is 1, oscillator edges are ignored and the count cannot fall.
- R7: `lock_o` is the registered result of `code_o` == Z. At most one of `lock_o`, `sat_hi_o` and `sat_lo_o` is 1 at any time.
- R8: The latched code stays correct after the internal up and down counts have each wrapped many times, as long as the inputs stay balanced.
- R9: When one input runs faster than the other, `code_o` settles at or beyond the corresponding threshold and never wraps past 0 or 2^W-1. This holds as long as fewer than 2^W-1-TU edges (or TL edges) arrive in one oscillator period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, faster than both inputs |
| rst | input | 1 | Synchronous reset, active high |
| rf_i | input | 1 | Digitised reference square wave |
| lo_i | input | 1 | Digitised local-oscillator square wave |
| code_o | output | W | Latched phase code for the DAC |
| sat_hi_o | output | 1 | Count is at or above the upper threshold |
| sat_lo_o | output | 1 | Count is at or below the lower threshold |
| lock_o | output | 1 | Count equals the zero code; enables the analog mixer |

## Verification
The bench runs a behavioural model alongside the design every clock. It also drives directed sequences aimed at four failure modes.

- Latch timing: a few reference edges are sent with no oscillator falling edge. A design that updates the code on the wrong edge would move the code before the oscillator falls.
- Counter wraparound: several hundred balanced edge pairs push both internal counts past their wrap point. A design that mishandles modular addition would report a far-off code.
- Saturation: long runs with one input much faster than the other drive the count to each threshold. Without the blocking logic, the code would roll over through the opposite extreme.
- Reset: a reset is applied mid-run. Any state left behind would appear as a wrong zero code or a wrong flag value.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic {CNT_UP = 1'b0, CNT_DOWN = 1'b1} cnt_dir_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync
  import pfd_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     din,
  output edge_ev_t ev
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign lvl = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  always_comb begin
    ev.rise = lvl & ~prev;
    ev.fall = ~lvl & prev;
  end
endmodule

// File: rtl/pfd_phase_counter.sv
module pfd_phase_counter
  import pfd_pkg::*;
#(
  parameter int           W    = 8,
  parameter cnt_dir_e     DIR  = CNT_UP,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         hold,
  output logic [W-1:0] cnt
);
  logic [W-1:0] nxt;

  generate
    if (DIR == CNT_UP) begin : g_up
      assign nxt = cnt + {{(W-1){1'b0}}, 1'b1};
    end else begin : g_down
      assign nxt = cnt - {{(W-1){1'b0}}, 1'b1};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)               cnt <= INIT;
    else if (step && !hold) cnt <= nxt;
  end
endmodule

// File: rtl/pfd_range_cmp.sv
module pfd_range_cmp #(
  parameter int           W    = 8,
  parameter logic [W-1:0] HI_T = '1,
  parameter logic [W-1:0] LO_T = '0,
  parameter logic [W-1:0] MID  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] n,
  output logic         at_hi,
  output logic         at_lo,
  output logic         at_mid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      at_hi  <= 1'b0;
      at_lo  <= 1'b0;
      at_mid <= 1'b1;
    end else begin
      at_hi  <= (n >= HI_T);
      at_lo  <= (n <= LO_T);
      at_mid <= (n == MID);
    end
  end
endmodule

// File: rtl/pfd_cycle_detector.sv
module pfd_cycle_detector
  import pfd_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TU          = (1 << W) - 4,
  parameter int TL          = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rf_i,
  input  logic         lo_i,
  output logic [W-1:0] code_o,
  output logic         sat_hi_o,
  output logic         sat_lo_o,
  output logic         lock_o
);
  localparam logic [W-1:0] ZERO_CODE = {1'b1, {(W-2){1'b0}}, 1'b1};
  localparam logic [W-1:0] TU_C      = TU[W-1:0];
  localparam logic [W-1:0] TL_C      = TL[W-1:0];

  edge_ev_t     rf_ev;
  edge_ev_t     lo_ev;
  logic         lo_fall;
  logic [W-1:0] rf_cnt;
  logic [W-1:0] lo_cnt;
  logic [W-1:0] phase_sum;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) rf_sync_i (
    .clk(clk), .rst(rst), .din(rf_i), .ev(rf_ev)
  );
  pfd_edge_sync #(.STAGES(SYNC_STAGES)) lo_sync_i (
    .clk(clk), .rst(rst), .din(lo_i), .ev(lo_ev)
  );

  pfd_phase_counter #(.W(W), .DIR(CNT_UP), .INIT(ZERO_CODE)) up_cnt_i (
    .clk(clk), .rst(rst), .step(rf_ev.rise), .hold(sat_hi_o), .cnt(rf_cnt)
  );
  pfd_phase_counter #(.W(W), .DIR(CNT_DOWN), .INIT('0)) dn_cnt_i (
    .clk(clk), .rst(rst), .step(lo_ev.rise), .hold(sat_lo_o), .cnt(lo_cnt)
  );

  assign lo_fall   = lo_ev.fall;
  assign phase_sum = rf_cnt + lo_cnt;

  always_ff @(posedge clk) begin
    if (rst)          code_o <= ZERO_CODE;
    else if (lo_fall) code_o <= phase_sum;
  end

  pfd_range_cmp #(.W(W), .HI_T(TU_C), .LO_T(TL_C), .MID(ZERO_CODE)) cmp_i (
    .clk(clk), .rst(rst), .n(code_o),
    .at_hi(sat_hi_o), .at_lo(sat_lo_o), .at_mid(lock_o)
  );
endmodule

// File: rtl/pfd_cycle_detector_chk.sv
module pfd_cycle_detector_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] code,
  input logic         hi,
  input logic         lo,
  input logic         lock,
  input logic         lo_fall,
  input logic [W-1:0] rf_cnt,
  input logic [W-1:0] lo_cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  a_r3_code_holds: assert property (@(posedge clk) disable iff (rst)
    !lo_fall |=> $stable(code));

  a_r5_up_blocked: assert property (@(posedge clk) disable iff (rst)
    hi |=> $stable(rf_cnt));

  a_r6_down_blocked: assert property (@(posedge clk) disable iff (rst)
    lo |=> $stable(lo_cnt));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hi, lo, lock}));

  a_r2_up_single_step: assert property (@(posedge clk) disable iff (rst)
    (rf_cnt == $past(rf_cnt)) || (rf_cnt == $past(rf_cnt) + ONE));

  a_r2_down_single_step: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt == $past(lo_cnt)) || (lo_cnt == $past(lo_cnt) - ONE));
endmodule

bind pfd_cycle_detector pfd_cycle_detector_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .code(code_o), .hi(sat_hi_o), .lo(sat_lo_o),
  .lock(lock_o), .lo_fall(lo_fall), .rf_cnt(rf_cnt), .lo_cnt(lo_cnt)
);

// File: tb/pfd_cycle_detector_tb.sv
module pfd_cycle_detector_tb_top;
  localparam int W  = 8;
  localparam int S  = 2;
  localparam int M  = 1 << W;
  localparam int TU = M - 4;
  localparam int TL = 3;
  localparam int Z  = (M / 2) + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rf  = 1'b0;
  logic         lo  = 1'b0;
  logic [W-1:0] code;
  logic         sat_hi, sat_lo, lock;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pfd_cycle_detector #(.W(W), .SYNC_STAGES(S), .TU(TU), .TL(TL)) dut_i (
    .clk(clk), .rst(rst), .rf_i(rf), .lo_i(lo),
    .code_o(code), .sat_hi_o(sat_hi), .sat_lo_o(sat_lo), .lock_o(lock)
  );

  // behavioural reference model
  int m_rfh [S];
  int m_loh [S];
  int m_rfp, m_lop, m_up, m_dn, m_code, m_hi, m_lo, m_lock;

  always @(posedge clk) begin
    int rl, ll, r_rise, l_rise, l_fall, old_code;
    if (rst) begin
      for (int i = 0; i < S; i++) begin m_rfh[i] = 0; m_loh[i] = 0; end
      m_rfp = 0; m_lop = 0; m_up = Z; m_dn = 0; m_code = Z;
      m_hi = 0; m_lo = 0; m_lock = 1;
    end else begin
      rl = m_rfh[S-1]; ll = m_loh[S-1];
      r_rise = (rl == 1 && m_rfp == 0); l_rise = (ll == 1 && m_lop == 0);
      l_fall = (ll == 0 && m_lop == 1);
      old_code = m_code;
      if (l_fall) m_code = (m_up + m_dn) % M;
      if (r_rise && m_hi == 0) m_up = (m_up + 1) % M;
      if (l_rise && m_lo == 0) m_dn = (m_dn + M - 1) % M;
      m_hi = (old_code >= TU); m_lo = (old_code <= TL); m_lock = (old_code == Z);
      m_rfp = rl; m_lop = ll;
      for (int i = S - 1; i > 0; i--) begin m_rfh[i] = m_rfh[i-1]; m_loh[i] = m_loh[i-1]; end
      m_rfh[0] = int'(rf); m_loh[0] = int'(lo);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(code) != m_code || int'(sat_hi) != m_hi || int'(sat_lo) != m_lo
          || int'(lock) != m_lock) begin
        errors++;
        $display("FAIL R4 model: code=%0d hi=%0d lo=%0d lock=%0d exp %0d %0d %0d %0d",
                 code, sat_hi, sat_lo, lock, m_code, m_hi, m_lo, m_lock);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rf_pulse(input int hi_c, input int lo_c);
    rf = 1'b1; cyc(hi_c); rf = 1'b0; cyc(lo_c);
  endtask

  task automatic lo_pulse(input int hi_c, input int lo_c);
    lo = 1'b1; cyc(hi_c); lo = 1'b0; cyc(lo_c);
  endtask

  task automatic do_reset();
    rst = 1'b1; rf = 1'b0; lo = 1'b0; cyc(4); rst = 1'b0; cyc(1);
  endtask

  int min_c, max_c;

  initial begin
    cyc(1);
    do_reset();
    chk("R1 code", int'(code), Z);
    chk("R1 lock", int'(lock), 1);
    chk("R1 sat_hi", int'(sat_hi), 0);
    chk("R1 sat_lo", int'(sat_lo), 0);

    // three reference edges, no oscillator fall yet
    for (int i = 0; i < 3; i++) rf_pulse(2, 2);
    cyc(8);
    chk("R3 hold before LO fall", int'(code), Z);
    lo_pulse(3, 8);
    chk("R2 code after +3-1", int'(code), Z + 2);
    chk("R7 lock off", int'(lock), 0);
    lo_pulse(3, 8);
    lo_pulse(3, 8);
    chk("R2 code back to zero", int'(code), Z);
    chk("R7 lock on", int'(lock), 1);
    lo_pulse(3, 8);
    chk("R2 code below zero", int'(code), Z - 1);

    // balanced run to wrap both internal counters (R8)
    do_reset();
    for (int i = 0; i < 300; i++) begin
      rf_pulse(2, 1);
      lo_pulse(2, 2);
    end
    cyc(8);
    chk("R8 code after wrap", int'(code), Z);
    chk("R8 lock after wrap", int'(lock), 1);

    // fast reference: drive to upper saturation (R5, R9)
    do_reset();
    min_c = M; max_c = 0;
    fork
      begin for (int i = 0; i < 600; i++) rf_pulse(2, 2); end
      begin for (int i = 0; i < 150; i++) begin
        lo_pulse(8, 8);
        if (int'(code) < min_c) min_c = int'(code);
      end end
    join
    cyc(20);
    chk("R5 sat_hi set", int'(sat_hi), 1);
    chk("R9 code at/above TU", int'(code) >= TU, 1);
    chk("R9 no wrap going up", min_c >= Z - 1, 1);

    // fast oscillator from saturated top: drive down (R6, R9)
    max_c = 0;
    fork
      begin for (int i = 0; i < 300; i++) rf_pulse(8, 8); end
      begin for (int i = 0; i < 1200; i++) begin
        lo_pulse(2, 2);
        if (i > 200 && int'(code) > max_c) max_c = int'(code);
      end end
    join
    cyc(20);
    chk("R6 sat_lo set", int'(sat_lo), 1);
    chk("R9 code at/below TL", int'(code) <= TL, 1);
    chk("R9 no wrap going down", max_c <= TU, 1);
    chk("R7 no hi with lo", int'(sat_hi), 0);

    // reset in the middle of saturation (R1)
    do_reset();
    chk("R1 code after mid reset", int'(code), Z);
    chk("R1 sat_lo cleared", int'(sat_lo), 0);
    chk("R1 lock after mid reset", int'(lock), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule